// File: doc/BRIEF.md
# Latched Address Chip-Select Decoder

This block sits between a processor's time-shared address bus and a small array of memory banks. While an address strobe is high, the upper part of the address flows straight through. When the strobe drops, the block keeps the value it saw last. The low five bits of that seven-bit upper address go out as the top address lines of each bank. The two remaining bits pick one of four banks through active-low select lines.

A separate active-low enable can turn off all four selects at any time. The enable is never captured: it acts on the select outputs at once, whatever the strobe is doing. If the strobe is tied high, the block is simply a combinational follower and bank decoder for a bus that is not multiplexed. Four banks of 8K bytes give a 32K-byte space, and smaller 4K-byte parts can use the same outputs.

Storage is a register on the system clock. It loads on every clock edge while the strobe is high. A bypass path makes the outputs follow the inputs during the strobe-high phase.

Top module: `addr_bank_latch`

## Requirements
- R1: While reset is applied, and after its release until the first strobe-high phase, `up_addr` is 0 and all four `bank_sel_n` lines are high.
- R2: While `strobe` is high, `up_addr` equals `hi_addr[4:0]` in the same cycle, without waiting for a clock edge.
- R3: After `strobe` falls, `up_addr` and the selects reflect the `hi_addr` value present at the last rising clock edge at which `strobe` was high.
- R4: While `strobe` is low, changes on `hi_addr` have no effect on `up_addr` or `bank_sel_n`.
- R5: With `ce_n` low, the bank code k = {bit 6, bit 5} of the effective address (bit 5 is the least significant bit of k) drives `bank_sel_n[k]` low, and the other three lines stay high. Exactly one line is low.
- R6: `ce_n` high forces all four `bank_sel_n` lines high. `ce_n` is not latched, so toggling it while `strobe` is low changes the selects in the same cycle, in both directions.
- R7: With `strobe` held high, every one of the 128 address values combined with either enable level gives outputs as a pure function of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the strobe is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hi_addr | input | 7 | Upper address byte from the bus (bits 4:0 pass through, bits 6:5 select a bank) |
| strobe | input | 1 | Address strobe: follow while high, hold while low |
| ce_n | input | 1 | Active-low enable for the bank selects, not latched |
| up_addr | output | 5 | Latched or followed upper address lines |
| bank_sel_n | output | 4 | Active-low one-of-four bank selects |

## Verification
Two events can land in the same cycle: the strobe falling, and a new, unrelated address appearing on the bus. The bench changes both on the same falling clock edge for every one of the 128 addresses. It then checks that the held value and the decoded select come from the address at the previous rising edge, not from the new bus value. A second case pairs an enable toggle with the held phase. It checks that the selects react at once while the held address stays unchanged.

// File: rtl/addr_bank_pkg.sv
package addr_bank_pkg;
  localparam int unsigned DEF_PASS_W = 5;
  localparam int unsigned DEF_SEL_W  = 2;
endpackage

// File: rtl/abl_rst_sync.sv
module abl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/abl_capture.sv
module abl_capture #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] held,
  output logic         seen
);
  logic [W-1:0] held_q, held_d;
  logic         seen_q, seen_d;

  always_comb begin
    held_d = held_q;
    seen_d = seen_q;
    if (load) begin
      held_d = d;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      seen_q <= 1'b0;
    end else begin
      held_q <= held_d;
      seen_q <= seen_d;
    end
  end

  assign held = held_q;
  assign seen = seen_q;

  // R3
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) && $past(rst_n) |-> held == $past(d));
endmodule

// File: rtl/abl_bank_decode.sv
module abl_bank_decode #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned NUM  = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] code,
  input  logic             en,
  output logic [NUM-1:0]   sel_n
);
  for (genvar i = 0; i < NUM; i++) begin : g_sel
    assign sel_n[i] = ~(en && (code == SEL_W'(i)));
  end

  // R5
  always_comb begin
    if (en) decode_onehot_chk: assert ($countones(~sel_n) == 1);
  end
endmodule

// File: rtl/addr_bank_latch.sv
module addr_bank_latch #(
  parameter int unsigned PASS_W = addr_bank_pkg::DEF_PASS_W,
  parameter int unsigned SEL_W  = addr_bank_pkg::DEF_SEL_W,
  localparam int unsigned IN_W  = PASS_W + SEL_W,
  localparam int unsigned NUM_SEL = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IN_W-1:0]    hi_addr,
  input  logic               strobe,
  input  logic               ce_n,
  output logic [PASS_W-1:0]  up_addr,
  output logic [NUM_SEL-1:0] bank_sel_n
);
  logic            rst_n_s;
  logic [IN_W-1:0] held;
  logic            seen;
  logic [IN_W-1:0] eff_addr;
  logic            follow;
  logic            sel_en;

  abl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  abl_capture #(.W(IN_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (strobe),
    .d     (hi_addr),
    .held  (held),
    .seen  (seen)
  );

  always_comb begin
    follow   = rst_n_s && strobe;
    eff_addr = follow ? hi_addr : held;
    sel_en   = rst_n_s && !ce_n && (follow || seen);
  end

  assign up_addr = eff_addr[PASS_W-1:0];

  abl_bank_decode #(.SEL_W(SEL_W)) u_dec (
    .code  (eff_addr[IN_W-1:PASS_W]),
    .en    (sel_en),
    .sel_n (bank_sel_n)
  );

  // R6
  ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ce_n |-> &bank_sel_n);

  // R3
  fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(strobe) && $past(rst_n_s) |-> up_addr == $past(hi_addr[PASS_W-1:0]));

  // R4
  low_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !strobe && $past(!strobe) && $past(rst_n_s) |-> $stable(up_addr));

  // R5
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ce_n && strobe |-> $countones(~bank_sel_n) == 1);

  // R1
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !strobe && !seen |-> &bank_sel_n);
endmodule

// File: tb/addr_bank_latch_test.sv
module addr_bank_latch_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] hi_addr;
  logic       strobe;
  logic       ce_n;
  logic [4:0] up_addr;
  logic [3:0] bank_sel_n;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  addr_bank_latch uut (
    .clk(clk), .rst_n(rst_n), .hi_addr(hi_addr), .strobe(strobe),
    .ce_n(ce_n), .up_addr(up_addr), .bank_sel_n(bank_sel_n)
  );

  function automatic logic [3:0] exp_sel(input logic [6:0] a, input logic ce);
    return ce ? 4'hF : ~(4'b0001 << a[6:5]);
  endfunction

  task automatic check(input string req, input logic [4:0] ea, input logic [3:0] es);
    checks++;
    if (up_addr !== ea || bank_sel_n !== es) begin
      failures++;
      $display("FAIL %s addr=%h sel=%b expected addr=%h sel=%b",
               req, up_addr, bank_sel_n, ea, es);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hi_addr = 7'h55; strobe = 1'b0; ce_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R1 in reset", 5'h00, 4'hF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    hi_addr = 7'h7F;
    #1 check("R1 after release, no strobe", 5'h00, 4'hF);

    // R2 / R5 / R7: strobe high, full sweep, follower
    @(negedge clk);
    strobe = 1'b1;
    for (int a = 0; a < 128; a++) begin
      for (int c = 0; c < 2; c++) begin
        hi_addr = 7'(a); ce_n = c[0];
        #1 check("R7 R2 R5 follow", 5'(a), exp_sel(7'(a), c[0]));
        #1;
      end
    end

    // R3 / R4: capture sweep, strobe fall and bus change in the same cycle
    ce_n = 1'b0;
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      strobe = 1'b1; hi_addr = 7'(a);
      @(negedge clk);
      strobe = 1'b0; hi_addr = ~7'(a);
      #1 check("R3 capture at fall", 5'(a), exp_sel(7'(a), 1'b0));
      @(negedge clk);
      hi_addr = 7'(a) ^ 7'h2A;
      #1 check("R4 held under bus change", 5'(a), exp_sel(7'(a), 1'b0));
    end

    // R6: enable toggled while held
    @(negedge clk);
    strobe = 1'b1; hi_addr = 7'h4B;
    @(negedge clk);
    strobe = 1'b0; hi_addr = 7'h00;
    #1 check("R6 held enabled", 5'h0B, exp_sel(7'h4B, 1'b0));
    @(negedge clk);
    ce_n = 1'b1;
    #1 check("R6 disabled while held", 5'h0B, 4'hF);
    #2 ce_n = 1'b0;
    #1 check("R6 re-enabled immediately", 5'h0B, exp_sel(7'h4B, 1'b0));
    @(negedge clk);
    hi_addr = 7'h33; ce_n = 1'b1;
    #1 check("R4 R6 change while low", 5'h0B, 4'hF);

    // R1: reset again while holding
    rst_n = 1'b0;
    #1 check("R1 async reset", 5'h00, 4'hF);
    ce_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R1 idle after second reset", 5'h00, 4'hF);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule